// File: doc/BRIEF.md
# Receive Descriptor Ownership Lookahead Controller

This block is the control state machine of a network receive path. It decides which host memory buffer gets each accepted incoming frame. It keeps a cached ownership flag for the current receive descriptor. When a frame arrives and that flag shows the host still holds the descriptor, the block polls it once more as a last chance. If the host still holds it, the frame is dropped and counted.

Once the current descriptor is owned, the block always reads ahead one entry. This lets a frame longer than one buffer continue into the next buffer without a pause. When the frame does not fit and the next buffer is not available, the current descriptor goes back to the host carrying an error status.

Every descriptor write-back clears the ownership bit of the addressed descriptor. Write-backs and polls each travel on their own valid/ready style handshake. The ring index steps through a programmable number of entries and wraps to zero. The bus master, the receive FIFO and address matching sit outside this block.

Top module: `rx_own_lookahead`

## Requirements
- R1: On `frm_accept` while idle, if the cached ownership of the current descriptor is clear, the first request is a poll of the current index. If the cached flag is set, the current index is not polled.
- R2: If that last-chance poll answers "not owned", `miss_evt` pulses for one cycle. After that there is no poll, no write-back and no `xfer_en` until `frm_done`, and then the block is idle again.
- R3: `miss_cnt` is a MISS_W-bit counter. It rises by one for each dropped frame and holds at all ones instead of wrapping.
- R4: Once the current descriptor is known to be owned, the block polls the next index. `xfer_en` is raised only after that poll has been acknowledged, whatever it answered.
- R5: `xfer_en` is low while the byte count stored in the current buffer equals `buf_len`. Each `wr_beat` stores one byte.
- R6: If the buffer is full, more data is available, and the next descriptor is owned, the block issues a write-back to the current index with `wb_stat`=0 (ownership cleared only). It then advances the current index and polls the entry after the new current one. Only then do transfers resume.
- R7: If the buffer is full, more data is available, and the next descriptor is not owned, the block issues a write-back with `wb_stat`=1, `wb_buff`=1, `wb_oflo` equal to `fifo_ovf` at the decision, and `wb_eop`=0. The current index advances, its cached ownership is cleared, and no more bytes are stored before `frm_done`.
- R8: `frm_done` during transfer issues a write-back with `wb_stat`=1, `wb_eop`=1, `wb_buff`=0 and `wb_mcnt` equal to the frame's total byte count. The current index then advances, and its cached ownership takes the lookahead result.
- R9: The next index after `ring_last` is 0.
- R10: While `wb_valid` is high and `wb_ready` is low, every write-back field holds its value, and both `poll_req` and `xfer_en` stay low.
- R11: While `poll_req` is high and `poll_ack` is low, `poll_idx` holds its value.
- R12: After reset, `poll_req`, `wb_valid`, `xfer_en` and `miss_cnt` are zero, the current index is 0, and its cached ownership is clear.
- R13: A frame whose length equals `buf_len` ends with a single end-of-packet write-back and no chaining write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_last | input | IDX_W | Index of the last ring entry (at least 1) |
| buf_len | input | BLEN_W | Byte capacity of each receive buffer |
| frm_accept | input | 1 | Pulse: a frame passed address matching |
| frm_done | input | 1 | Pulse: the last byte of the frame has left the FIFO |
| data_avail | input | 1 | The FIFO holds further bytes of the current frame |
| fifo_ovf | input | 1 | The FIFO overflowed during this frame |
| wr_beat | input | 1 | One byte was stored into the current buffer |
| xfer_en | output | 1 | Byte transfers into the current buffer are allowed |
| poll_req | output | 1 | Descriptor ownership read request |
| poll_idx | output | IDX_W | Ring index to read |
| poll_ack | input | 1 | Poll answered this cycle |
| poll_own | input | 1 | Answer: the controller owns the descriptor |
| wb_valid | output | 1 | Descriptor write-back request (always clears ownership) |
| wb_ready | input | 1 | Write-back accepted |
| wb_idx | output | IDX_W | Ring index being written back |
| wb_stat | output | 1 | Status fields are written too |
| wb_buff | output | 1 | Buffer error flag |
| wb_oflo | output | 1 | Overflow flag |
| wb_eop | output | 1 | End-of-packet flag |
| wb_mcnt | output | MCNT_W | Frame byte count |
| miss_evt | output | 1 | Pulse: frame dropped for lack of a buffer |
| miss_cnt | output | MISS_W | Saturating count of dropped frames |

## Verification
The assertions rely on a few assumptions about the inputs:
- `ring_last` and `buf_len` stay constant during operation.
- `wr_beat` comes only while `xfer_en` is high.
- `frm_done` comes once per accepted frame.
- `frm_accept` comes only while the block is idle.

The stimulus meets these conditions because of how it is built. A single driver task runs each frame from accept to `frm_done` and waits for the write-back to drain before starting the next one. It stores a byte only in a cycle where it sees `xfer_en` high. For frames that are expected to be dropped, it sends `frm_done` only after a quiet period. The poll and write-back responders add their own delays, so the stall paths are exercised, but they answer only requests that are pending.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LAST_POLL,
        ST_MISSED,
        ST_NEXT_POLL,
        ST_XFER,
        ST_WB_CHAIN,
        ST_AHEAD_POLL,
        ST_WB_ERR,
        ST_DROP,
        ST_WB_END
    } rxo_state_e;

    typedef struct packed {
        logic stat;
        logic buff;
        logic oflo;
        logic eop;
    } rxo_wb_flags_t;

    function automatic rxo_wb_flags_t wb_flags_for(input rxo_state_e st, input logic oflo);
        rxo_wb_flags_t f;
        f = '0;
        case (st)
            ST_WB_ERR: begin f.stat = 1'b1; f.buff = 1'b1; f.oflo = oflo; end
            ST_WB_END: begin f.stat = 1'b1; f.eop = 1'b1; end
            default:   f = '0;
        endcase
        return f;
    endfunction

    function automatic logic is_wb_state(input rxo_state_e st);
        return (st == ST_WB_CHAIN) || (st == ST_WB_ERR) || (st == ST_WB_END);
    endfunction

endpackage

// File: rtl/rxo_ring_ptr.sv
module rxo_ring_ptr #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ring_last,
    input  logic             advance,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] nxt_idx
);
    logic [IDX_W-1:0] cur_q;

    always_comb begin
        if (cur_q >= ring_last) nxt_idx = '0;
        else                    nxt_idx = cur_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          cur_q <= '0;
        else if (advance) cur_q <= nxt_idx;
    end

    assign cur_idx = cur_q;
endmodule

// File: rtl/rxo_len_track.sv
module rxo_len_track #(
    parameter int BLEN_W = 12,
    parameter int MCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_frame,
    input  logic              clr_buf,
    input  logic              beat,
    input  logic [BLEN_W-1:0] buf_len,
    output logic              buf_full,
    output logic [MCNT_W-1:0] frm_bytes
);
    logic [BLEN_W-1:0] buf_cnt;
    logic [MCNT_W-1:0] frm_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_frame) begin
            buf_cnt <= '0;
            frm_cnt <= '0;
        end else begin
            if (clr_buf)   buf_cnt <= '0;
            else if (beat) buf_cnt <= buf_cnt + 1'b1;
            if (beat)      frm_cnt <= frm_cnt + 1'b1;
        end
    end

    assign buf_full  = (buf_cnt == buf_len);
    assign frm_bytes = frm_cnt;
endmodule

// File: rtl/rxo_sat_cnt.sv
module rxo_sat_cnt #(
    parameter int CNT_W    = 16,
    parameter bit SATURATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    generate
        if (SATURATE) begin : g_sat
            assign step = inc && !(&cnt_q);
        end else begin : g_wrap
            assign step = inc;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rxo_fsm.sv
module rxo_fsm
    import rxo_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          frm_accept,
    input  logic          frm_done,
    input  logic          data_avail,
    input  logic          fifo_ovf,
    input  logic          buf_full,
    input  logic          poll_ack,
    input  logic          poll_own,
    input  logic          wb_ready,
    output logic          poll_req,
    output logic          poll_sel_nxt,
    output logic          wb_valid,
    output rxo_wb_flags_t wb_flags,
    output logic          advance,
    output logic          clr_frame,
    output logic          clr_buf,
    output logic          xfer_en,
    output logic          miss_evt
);
    rxo_state_e st_q, st_d;
    logic cur_own_q, cur_own_d;
    logic nxt_own_q, nxt_own_d;
    logic oflo_q, oflo_d;
    logic miss_d;

    always_comb begin
        st_d      = st_q;
        cur_own_d = cur_own_q;
        nxt_own_d = nxt_own_q;
        oflo_d    = oflo_q;
        miss_d    = 1'b0;
        advance   = 1'b0;
        clr_frame = 1'b0;
        clr_buf   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (frm_accept) begin
                    clr_frame = 1'b1;
                    st_d      = cur_own_q ? ST_NEXT_POLL : ST_LAST_POLL;
                end
            end
            ST_LAST_POLL: begin
                if (poll_ack) begin
                    if (poll_own) begin
                        cur_own_d = 1'b1;
                        st_d      = ST_NEXT_POLL;
                    end else begin
                        miss_d = 1'b1;
                        st_d   = ST_MISSED;
                    end
                end
            end
            ST_MISSED: begin
                if (frm_done) st_d = ST_IDLE;
            end
            ST_NEXT_POLL, ST_AHEAD_POLL: begin
                if (poll_ack) begin
                    nxt_own_d = poll_own;
                    st_d      = ST_XFER;
                end
            end
            ST_XFER: begin
                if (frm_done) begin
                    st_d = ST_WB_END;
                end else if (buf_full && data_avail) begin
                    if (nxt_own_q) begin
                        st_d = ST_WB_CHAIN;
                    end else begin
                        oflo_d = fifo_ovf;
                        st_d   = ST_WB_ERR;
                    end
                end
            end
            ST_WB_CHAIN: begin
                if (wb_ready) begin
                    advance   = 1'b1;
                    clr_buf   = 1'b1;
                    cur_own_d = 1'b1;
                    nxt_own_d = 1'b0;
                    st_d      = ST_AHEAD_POLL;
                end
            end
            ST_WB_ERR: begin
                if (wb_ready) begin
                    advance   = 1'b1;
                    clr_buf   = 1'b1;
                    cur_own_d = 1'b0;
                    nxt_own_d = 1'b0;
                    st_d      = ST_DROP;
                end
            end
            ST_DROP: begin
                if (frm_done) st_d = ST_IDLE;
            end
            ST_WB_END: begin
                if (wb_ready) begin
                    advance   = 1'b1;
                    cur_own_d = nxt_own_q;
                    nxt_own_d = 1'b0;
                    st_d      = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cur_own_q <= 1'b0;
            nxt_own_q <= 1'b0;
            oflo_q    <= 1'b0;
            miss_evt  <= 1'b0;
        end else begin
            st_q      <= st_d;
            cur_own_q <= cur_own_d;
            nxt_own_q <= nxt_own_d;
            oflo_q    <= oflo_d;
            miss_evt  <= miss_d;
        end
    end

    assign poll_req     = (st_q == ST_LAST_POLL) || (st_q == ST_NEXT_POLL) || (st_q == ST_AHEAD_POLL);
    assign poll_sel_nxt = (st_q != ST_LAST_POLL);
    assign wb_valid     = is_wb_state(st_q);
    assign wb_flags     = wb_flags_for(st_q, oflo_q);
    assign xfer_en      = (st_q == ST_XFER) && !buf_full;
endmodule

// File: rtl/rx_own_lookahead.sv
module rx_own_lookahead
    import rxo_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int BLEN_W = 12,
    parameter int MCNT_W = 16,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ring_last,
    input  logic [BLEN_W-1:0] buf_len,
    input  logic              frm_accept,
    input  logic              frm_done,
    input  logic              data_avail,
    input  logic              fifo_ovf,
    input  logic              wr_beat,
    output logic              xfer_en,
    output logic              poll_req,
    output logic [IDX_W-1:0]  poll_idx,
    input  logic              poll_ack,
    input  logic              poll_own,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [IDX_W-1:0]  wb_idx,
    output logic              wb_stat,
    output logic              wb_buff,
    output logic              wb_oflo,
    output logic              wb_eop,
    output logic [MCNT_W-1:0] wb_mcnt,
    output logic              miss_evt,
    output logic [MISS_W-1:0] miss_cnt
);
    logic [IDX_W-1:0] cur_idx, nxt_idx;
    logic             advance, clr_frame, clr_buf, buf_full, poll_sel_nxt;
    rxo_wb_flags_t    flags;

    rxo_ring_ptr #(.IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst(rst), .ring_last(ring_last), .advance(advance),
        .cur_idx(cur_idx), .nxt_idx(nxt_idx)
    );

    rxo_len_track #(.BLEN_W(BLEN_W), .MCNT_W(MCNT_W)) u_len (
        .clk(clk), .rst(rst), .clr_frame(clr_frame), .clr_buf(clr_buf),
        .beat(wr_beat), .buf_len(buf_len), .buf_full(buf_full), .frm_bytes(wb_mcnt)
    );

    rxo_sat_cnt #(.CNT_W(MISS_W), .SATURATE(1'b1)) u_miss (
        .clk(clk), .rst(rst), .inc(miss_evt), .cnt(miss_cnt)
    );

    rxo_fsm u_fsm (
        .clk(clk), .rst(rst), .frm_accept(frm_accept), .frm_done(frm_done),
        .data_avail(data_avail), .fifo_ovf(fifo_ovf), .buf_full(buf_full),
        .poll_ack(poll_ack), .poll_own(poll_own), .wb_ready(wb_ready),
        .poll_req(poll_req), .poll_sel_nxt(poll_sel_nxt), .wb_valid(wb_valid),
        .wb_flags(flags), .advance(advance), .clr_frame(clr_frame), .clr_buf(clr_buf),
        .xfer_en(xfer_en), .miss_evt(miss_evt)
    );

    assign poll_idx = poll_sel_nxt ? nxt_idx : cur_idx;
    assign wb_idx   = cur_idx;
    assign wb_stat  = flags.stat;
    assign wb_buff  = flags.buff;
    assign wb_oflo  = flags.oflo;
    assign wb_eop   = flags.eop;
endmodule

// File: rtl/rx_own_lookahead_chk.sv
module rx_own_lookahead_chk #(
    parameter int IDX_W  = 7,
    parameter int MCNT_W = 16,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  ring_last,
    input logic              frm_done,
    input logic              xfer_en,
    input logic              poll_req,
    input logic [IDX_W-1:0]  poll_idx,
    input logic              poll_ack,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [IDX_W-1:0]  wb_idx,
    input logic              wb_stat,
    input logic              wb_buff,
    input logic              wb_oflo,
    input logic              wb_eop,
    input logic [MCNT_W-1:0] wb_mcnt,
    input logic              miss_evt,
    input logic [MISS_W-1:0] miss_cnt
);
    logic missing;

    always_ff @(posedge clk) begin
        if (rst)           missing <= 1'b0;
        else if (miss_evt) missing <= 1'b1;
        else if (frm_done) missing <= 1'b0;
    end

    p_poll_hold_r11: assert property (@(posedge clk) disable iff (rst)
        poll_req && !poll_ack |=> poll_req && $stable(poll_idx));

    p_wb_hold_r10: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ready |=> wb_valid &&
            $stable({wb_idx, wb_stat, wb_buff, wb_oflo, wb_eop, wb_mcnt}));

    p_wb_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !xfer_en && !poll_req);

    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (missing || miss_evt) |-> !poll_req && !wb_valid && !xfer_en);

    p_miss_step_r3: assert property (@(posedge clk) disable iff (rst)
        miss_evt |=> (miss_cnt == MISS_W'($past(miss_cnt) + 1'b1)) ||
                     ((&$past(miss_cnt)) && (&miss_cnt)));

    p_miss_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !miss_evt |=> $stable(miss_cnt));

    p_end_flags_r8: assert property (@(posedge clk) disable iff (rst)
        wb_valid && wb_eop |-> wb_stat && !wb_buff);

    p_err_flags_r7: assert property (@(posedge clk) disable iff (rst)
        wb_valid && wb_oflo |-> wb_buff && !wb_eop);

    p_ring_range_r9: assert property (@(posedge clk) disable iff (rst)
        (poll_req |-> poll_idx <= ring_last) and (wb_valid |-> wb_idx <= ring_last));

    p_xfer_after_poll_r4: assert property (@(posedge clk) disable iff (rst)
        xfer_en |-> !poll_req);
endmodule

bind rx_own_lookahead rx_own_lookahead_chk #(
    .IDX_W(IDX_W), .MCNT_W(MCNT_W), .MISS_W(MISS_W)
) u_chk (
    .clk(clk), .rst(rst), .ring_last(ring_last), .frm_done(frm_done),
    .xfer_en(xfer_en), .poll_req(poll_req), .poll_idx(poll_idx), .poll_ack(poll_ack),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx), .wb_stat(wb_stat),
    .wb_buff(wb_buff), .wb_oflo(wb_oflo), .wb_eop(wb_eop), .wb_mcnt(wb_mcnt),
    .miss_evt(miss_evt), .miss_cnt(miss_cnt)
);

// File: tb/rx_own_lookahead_test.sv
module rx_own_lookahead_test;
    localparam int IDX_W  = 3;
    localparam int BLEN_W = 8;
    localparam int MCNT_W = 12;
    localparam int MISS_W = 4;
    localparam int BL     = 8;
    localparam int LAST   = 3;
    localparam int WBW    = IDX_W + 4 + MCNT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IDX_W-1:0]  ring_last = IDX_W'(LAST);
    logic [BLEN_W-1:0] buf_len = BLEN_W'(BL);
    logic frm_accept = 0, frm_done = 0, data_avail = 0, fifo_ovf = 0, wr_beat = 0;
    logic poll_ack = 0, poll_own = 0, wb_ready = 0;
    logic xfer_en, poll_req, wb_valid, wb_stat, wb_buff, wb_oflo, wb_eop, miss_evt;
    logic [IDX_W-1:0]  poll_idx, wb_idx;
    logic [MCNT_W-1:0] wb_mcnt;
    logic [MISS_W-1:0] miss_cnt;

    always #2.5 clk = ~clk;

    rx_own_lookahead #(.IDX_W(IDX_W), .BLEN_W(BLEN_W), .MCNT_W(MCNT_W), .MISS_W(MISS_W)) uut (
        .clk(clk), .rst(rst), .ring_last(ring_last), .buf_len(buf_len),
        .frm_accept(frm_accept), .frm_done(frm_done), .data_avail(data_avail),
        .fifo_ovf(fifo_ovf), .wr_beat(wr_beat), .xfer_en(xfer_en),
        .poll_req(poll_req), .poll_idx(poll_idx), .poll_ack(poll_ack), .poll_own(poll_own),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx), .wb_stat(wb_stat),
        .wb_buff(wb_buff), .wb_oflo(wb_oflo), .wb_eop(wb_eop), .wb_mcnt(wb_mcnt),
        .miss_evt(miss_evt), .miss_cnt(miss_cnt)
    );

    int checks = 0, errors = 0;
    logic [7:0] own_tbl = '0;
    int poll_delay = 0, wb_delay = 0;
    int polls_seen = 0;

    int            exp_poll_q[$];
    string         poll_tag_q[$];
    logic [WBW-1:0] exp_wb_q[$];
    string         wb_tag_q[$];

    int m_cur = 0; bit m_cur_own = 0; bit m_nxt_own = 0; int m_miss = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int nx(input int i);
        return (i >= LAST) ? 0 : i + 1;
    endfunction

    // Poll responder and monitor
    int pdly = 0; int pcap = 0;
    always @(negedge clk) begin
        if (poll_ack) begin
            poll_ack = 1'b0;
        end else if (poll_req && !rst) begin
            if (pdly == 0) pcap = int'(poll_idx);
            if (pdly < poll_delay) begin
                pdly++;
            end else begin
                chk(int'(poll_idx) == pcap, "R11", "poll index held", int'(poll_idx), pcap);
                poll_own = own_tbl[poll_idx];
                poll_ack = 1'b1;
                polls_seen++;
                if (exp_poll_q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected poll", int'(poll_idx), -1);
                end else begin
                    automatic int e = exp_poll_q.pop_front();
                    automatic string t = poll_tag_q.pop_front();
                    chk(int'(poll_idx) == e, t, "poll index", int'(poll_idx), e);
                end
                pdly = 0;
            end
        end
    end

    // Write-back responder and monitor
    int wdly = 0; logic [WBW-1:0] wcap; bit wviol = 0;
    always @(negedge clk) begin
        automatic logic [WBW-1:0] act = {wb_idx, wb_stat, wb_buff, wb_oflo, wb_eop, wb_mcnt};
        if (wb_ready) begin
            wb_ready = 1'b0;
        end else if (wb_valid && !rst) begin
            if (wdly == 0) begin wcap = act; wviol = 0; end
            if (xfer_en || poll_req) wviol = 1;
            if (wdly < wb_delay) begin
                wdly++;
            end else begin
                chk(act == wcap && !wviol, "R10", "write-back held while stalled", int'(act), int'(wcap));
                wb_ready = 1'b1;
                if (exp_wb_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected write-back", int'(act), -1);
                end else begin
                    automatic logic [WBW-1:0] e = exp_wb_q.pop_front();
                    automatic string t = wb_tag_q.pop_front();
                    chk(act == e, t, "write-back fields", int'(act), int'(e));
                end
                wdly = 0;
            end
        end
    end

    task automatic push_poll(input int idx, input string tag);
        exp_poll_q.push_back(idx); poll_tag_q.push_back(tag);
    endtask

    task automatic push_wb(input int idx, input bit st, input bit bf, input bit of, input bit ep,
                           input int mc, input string tag);
        exp_wb_q.push_back({IDX_W'(idx), st, bf, of, ep, MCNT_W'(mc)}); wb_tag_q.push_back(tag);
    endtask

    // Model: pushes the expected polls and write-backs of one frame
    task automatic predict(input int len, input bit ovf, output int stored, output int ipolls, output bit drop);
        int rem;
        stored = 0; ipolls = 0; drop = 0;
        if (!m_cur_own) begin
            push_poll(m_cur, "R1"); ipolls++;
            if (!own_tbl[m_cur]) begin drop = 1; m_miss++; return; end
            m_cur_own = 1;
        end
        push_poll(nx(m_cur), "R4"); ipolls++;
        m_nxt_own = own_tbl[nx(m_cur)];
        rem = len;
        forever begin
            if (rem <= BL) begin
                push_wb(m_cur, 1, 0, 0, 1, len, (len == BL) ? "R13" : "R8");
                stored += rem; m_cur = nx(m_cur); m_cur_own = m_nxt_own;
                return;
            end
            if (m_nxt_own) begin
                push_wb(m_cur, 0, 0, 0, 0, stored + BL, "R6");
                stored += BL; rem -= BL; m_cur = nx(m_cur);
                push_poll(nx(m_cur), (nx(m_cur) == 0) ? "R9" : "R6");
                m_nxt_own = own_tbl[nx(m_cur)];
            end else begin
                push_wb(m_cur, 1, 1, ovf, 0, stored + BL, "R7");
                stored += BL; m_cur = nx(m_cur); m_cur_own = 0; drop = 1;
                return;
            end
        end
    endtask

    task automatic run_frame(input int len, input bit ovf);
        int stored, ipolls, rem, beats, idle;
        bit drop, first;
        predict(len, ovf, stored, ipolls, drop);
        @(negedge clk);
        polls_seen = 0;
        frm_accept = 1; data_avail = 1; fifo_ovf = ovf;
        rem = len; beats = 0; idle = 0; first = 1;
        forever begin
            @(negedge clk);
            frm_accept = 0; wr_beat = 0; frm_done = 0;
            if (xfer_en && rem > 0) begin
                if (first) begin
                    chk(polls_seen == ipolls, "R4", "polls before first transfer", polls_seen, ipolls);
                    first = 0;
                end
                wr_beat = 1; rem--; beats++; data_avail = (rem > 0);
            end else if (rem == 0 && !drop) begin
                frm_done = 1; break;
            end else begin
                idle++;
                if (drop && idle > 25) begin frm_done = 1; break; end
            end
        end
        @(negedge clk);
        frm_done = 0; data_avail = 0; fifo_ovf = 0;
        repeat (12) @(negedge clk);
        chk(beats == stored, drop ? ((stored == 0) ? "R2" : "R5") : "R8", "bytes stored", beats, stored);
        chk(int'(miss_cnt) == ((m_miss > 15) ? 15 : m_miss), "R3", "missed count", int'(miss_cnt),
            (m_miss > 15) ? 15 : m_miss);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        chk(1'b0, "R12", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!poll_req, "R12", "poll_req after reset", int'(poll_req), 0);
        chk(!wb_valid, "R12", "wb_valid after reset", int'(wb_valid), 0);
        chk(!xfer_en, "R12", "xfer_en after reset", int'(xfer_en), 0);
        chk(miss_cnt == 0, "R12", "miss_cnt after reset", int'(miss_cnt), 0);

        // R2: nothing owned, index 0 polled and frame dropped
        run_frame(5, 0);
        // R1 R4 R8: all owned, single-buffer frame
        own_tbl = 8'hFF;
        run_frame(5, 0);
        // R13: exact fit, cached ownership skips the last-chance poll
        run_frame(BL, 0);
        // R6 R9 R10 R11: chaining across two boundaries with ring wrap, slow responders
        poll_delay = 2; wb_delay = 3;
        run_frame(20, 0);
        poll_delay = 0; wb_delay = 1;
        // R7 R5: next not owned, overflow flag carried
        own_tbl[2] = 0;
        run_frame(12, 1);
        // R2: new current is not owned either
        run_frame(4, 0);
        own_tbl[2] = 1;
        run_frame(3, 0);
        // R7 with overflow clear
        own_tbl = 8'h00;
        run_frame(11, 0);
        // R3: saturation of the missed counter
        for (int i = 0; i < 16; i++) run_frame(2, 0);

        chk(exp_poll_q.size() == 0, "R4", "expected polls left", exp_poll_q.size(), 0);
        chk(exp_wb_q.size() == 0, "R8", "expected write-backs left", exp_wb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule